// File: doc/BRIEF.md
# Programmable-Precision Significand Rounder

This block takes a 64-bit significand together with three extra low-order bits (guard, round, sticky) and the sign of the value. It rounds the significand to 24, 53 or 64 significant bits. The rounding direction and the precision come from a 16-bit control word, which the block keeps in its own register and which software loads through a simple write port. The word can be read back at any time.

Each request passes through one register stage. The result is the rounded significand with every bit below the chosen precision cleared. With it come a flag telling the exponent logic that rounding carried out of the top bit, and an inexact indication. Any inexact result sets a sticky status bit. The inexact indication also reaches an unmasked-exception output when the precision mask bit of the control word is clear. Operations that must not round drop their per-request round enable, and their significand passes through untouched.

Top module: `xpr_round_unit`

## Requirements
- R1: After reset the control word reads 16'h037F. A write loads all 16 bits, and the word reads back exactly as written, including bits that have no function.
- R2: Control bits 9:8 pick the precision: 00 keeps 24 bits, 10 keeps 53 bits, and 11 or 01 keep 64 bits. Every significand bit below the kept ones is zero in the result.
- R3: With control bits 11:10 = 00, the magnitude is incremented when the first discarded bit is 1 and either some lower discarded bit or the kept LSB is 1 (nearest, ties to even).
- R4: With control bits 11:10 = 11, the kept bits are never incremented (truncation).
- R5: With control bits 11:10 = 10, the magnitude is incremented only when in_sign is 0 and a discarded bit is nonzero. With 01, it is incremented only when in_sign is 1 and a discarded bit is nonzero.
- R6: When the increment overflows the top significand bit, out_sig is 1 in bit 63 and 0 elsewhere, and out_exp_inc is 1. Otherwise out_exp_inc is 0.
- R7: out_inexact is 1 exactly when some discarded bit is nonzero. The discarded bits are the significand bits below the precision plus in_grs, where in_grs[2] is guard, in_grs[1] is round and in_grs[0] is sticky.
- R8: pe_status is 0 after reset. It becomes 1 together with the first valid inexact result and then stays 1.
- R9: out_pe_unmasked is 1 only with a valid inexact result, and only when control bit 5 was 0 for that request.
- R10: With in_round_en = 0, out_sig equals in_sig, out_inexact and out_exp_inc are 0, and pe_status is unaffected.
- R11: Every cycle with in_valid = 1 produces exactly one cycle of out_valid = 1 on the next cycle, in order.
- R12: A request uses the control word held before its cycle, even when a write to the control word occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_we | input | 1 | Control word write strobe |
| cw_wdata | input | 16 | Control word write data |
| cw_q | output | 16 | Current control word |
| in_valid | input | 1 | Request present |
| in_round_en | input | 1 | 1 = round this request, 0 = pass it through |
| in_sign | input | 1 | Sign of the value (1 = negative) |
| in_sig | input | 64 | Significand to round |
| in_grs | input | 3 | Guard, round and sticky bits below in_sig |
| out_valid | output | 1 | Result present |
| out_sig | output | 64 | Rounded significand |
| out_exp_inc | output | 1 | Rounding carried out; the exponent must be incremented |
| out_inexact | output | 1 | Result differs from the input |
| out_pe_unmasked | output | 1 | Inexact result with the precision mask clear |
| pe_status | output | 1 | Sticky inexact status |

## Verification
The clocked checks assume that in_valid, in_round_en and the control word are never unknown outside reset. They also assume that the request and its fields are stable across the capturing edge, so that the value sampled one cycle earlier is the value the stage captured. The bench drives every input only on the falling edge, and it holds in_valid and cw_we at defined levels from time zero through reset. The random phase draws every field over its full range, including the unused precision code, so that no input pattern falls outside what the checks assume.

// File: rtl/xpr_pkg.sv
package xpr_pkg;

   // Field positions inside the control word (decoded by xpr_cw_reg).
   localparam int RC_LSB      = 10;
   localparam int PC_LSB      = 8;
   localparam int PE_MASK_BIT = 5;
   localparam int GRS_W       = 3;

   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_DOWN = 2'b01,
      RM_UP   = 2'b10,
      RM_CHOP = 2'b11
   } rmode_e;

   typedef enum logic [1:0] {
      PS_NARROW = 2'd0,
      PS_MID    = 2'd1,
      PS_FULL   = 2'd2
   } psel_e;

   // Decide whether the kept magnitude must grow by one unit in the last place.
   function automatic logic inc_needed(rmode_e rm, logic neg, logic lsb,
                                       logic rb, logic sb);
      logic bump;
      case (rm)
         RM_NEAR: bump = rb & (sb | lsb);
         RM_DOWN: bump = neg & (rb | sb);
         RM_UP:   bump = ~neg & (rb | sb);
         default: bump = 1'b0;
      endcase
      return bump;
   endfunction

endpackage

// File: rtl/xpr_cw_reg.sv
module xpr_cw_reg
   import xpr_pkg::*;
#(
   parameter int              CW_W = 16,
   parameter logic [CW_W-1:0] INIT = 16'h037F
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [CW_W-1:0] wdata,
   output logic [CW_W-1:0] word_o,
   output rmode_e          rm_o,
   output psel_e           ps_o,
   output logic            pe_masked_o
);

   logic [CW_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= INIT;
      else if (we) word_q <= wdata;
   end

   assign word_o      = word_q;
   assign rm_o        = rmode_e'(word_q[RC_LSB +: 2]);
   assign pe_masked_o = word_q[PE_MASK_BIT];

   always_comb begin
      case (word_q[PC_LSB +: 2])
         2'b00:   ps_o = PS_NARROW;
         2'b10:   ps_o = PS_MID;
         default: ps_o = PS_FULL;  // 11, and the unused code 01
      endcase
   end

   // A write is visible, unaltered, on the next cycle.
   assert_word_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (word_o == $past(wdata)));

endmodule

// File: rtl/xpr_lane.sv
module xpr_lane
   import xpr_pkg::*;
#(
   parameter int SIG_W = 64,
   parameter int KEEP  = 64
) (
   input  logic [SIG_W-1:0] sig_i,
   input  logic [GRS_W-1:0] grs_i,
   input  logic             sign_i,
   input  rmode_e           rm_i,
   output logic [SIG_W-1:0] sig_o,
   output logic             carry_o,
   output logic             inexact_o
);

   localparam int DROP = SIG_W - KEEP;
   localparam logic [SIG_W-1:0] TOP_ONLY = {1'b1, {(SIG_W-1){1'b0}}};

   logic [KEEP-1:0] kept;
   logic            rb;
   logic            sb;
   logic            bump;
   logic [KEEP:0]   sum;

   generate
      if (DROP == 0) begin : g_full
         assign kept = sig_i;
         assign rb   = grs_i[2];
         assign sb   = |grs_i[1:0];
      end else if (DROP >= 2) begin : g_part
         assign kept = sig_i[SIG_W-1:DROP];
         assign rb   = sig_i[DROP-1];
         assign sb   = (|sig_i[DROP-2:0]) | (|grs_i);
      end else begin : g_bad
         $error("xpr_lane: KEEP must equal SIG_W or leave at least two bits");
      end
   endgenerate

   assign bump      = inc_needed(rm_i, sign_i, kept[0], rb, sb);
   assign sum       = {1'b0, kept} + {{KEEP{1'b0}}, bump};
   assign carry_o   = sum[KEEP];
   assign inexact_o = rb | sb;

   generate
      if (DROP == 0) begin : g_out_full
         assign sig_o = carry_o ? TOP_ONLY : sum[KEEP-1:0];
      end else begin : g_out_part
         assign sig_o = carry_o ? TOP_ONLY : {sum[KEEP-1:0], {DROP{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/xpr_pe_flag.sv
module xpr_pe_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic take_i,
   input  logic masked_i,
   output logic status_o,
   output logic unmasked_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_o   <= 1'b0;
         unmasked_o <= 1'b0;
      end else begin
         if (take_i) status_o <= 1'b1;
         unmasked_o <= take_i & ~masked_i;
      end
   end

   // The status never drops once set.
   assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      status_o |=> status_o);

endmodule

// File: rtl/xpr_round_unit.sv
module xpr_round_unit
   import xpr_pkg::*;
#(
   parameter int              SIG_W       = 64,
   parameter int              CW_W        = 16,
   parameter logic [CW_W-1:0] CW_INIT     = 16'h037F,
   parameter int              NARROW_BITS = 24,
   parameter int              MID_BITS    = 53
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cw_we,
   input  logic [CW_W-1:0]  cw_wdata,
   output logic [CW_W-1:0]  cw_q,
   input  logic             in_valid,
   input  logic             in_round_en,
   input  logic             in_sign,
   input  logic [SIG_W-1:0] in_sig,
   input  logic [GRS_W-1:0] in_grs,
   output logic             out_valid,
   output logic [SIG_W-1:0] out_sig,
   output logic             out_exp_inc,
   output logic             out_inexact,
   output logic             out_pe_unmasked,
   output logic             pe_status
);

   localparam int NLANE = 3;
   localparam logic [SIG_W-1:0] TOP_ONLY = {1'b1, {(SIG_W-1){1'b0}}};

   generate
      if (CW_W < RC_LSB + 2) begin : g_chk_cw
         $error("xpr_round_unit: control word too narrow for its fields");
      end
      if (!(NARROW_BITS >= 2 && NARROW_BITS < MID_BITS && MID_BITS <= SIG_W - 2)) begin : g_chk_prec
         $error("xpr_round_unit: precision widths out of order");
      end
   endgenerate

   rmode_e cw_rm;
   psel_e  cw_ps;
   logic   cw_pe_masked;

   xpr_cw_reg #(.CW_W(CW_W), .INIT(CW_INIT)) u_cw (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cw_we),
      .wdata      (cw_wdata),
      .word_o     (cw_q),
      .rm_o       (cw_rm),
      .ps_o       (cw_ps),
      .pe_masked_o(cw_pe_masked)
   );

   logic [SIG_W-1:0] lane_sig [NLANE];
   logic [NLANE-1:0] lane_cy;
   logic [NLANE-1:0] lane_ix;

   generate
      for (genvar g = 0; g < NLANE; g++) begin : g_lane
         localparam int KEEP_G = (g == 0) ? NARROW_BITS : ((g == 1) ? MID_BITS : SIG_W);
         xpr_lane #(.SIG_W(SIG_W), .KEEP(KEEP_G)) u_lane (
            .sig_i    (in_sig),
            .grs_i    (in_grs),
            .sign_i   (in_sign),
            .rm_i     (cw_rm),
            .sig_o    (lane_sig[g]),
            .carry_o  (lane_cy[g]),
            .inexact_o(lane_ix[g])
         );
      end
   endgenerate

   logic [SIG_W-1:0] nxt_sig;
   logic             nxt_cy;
   logic             nxt_ix;

   always_comb begin
      nxt_sig = in_sig;
      nxt_cy  = 1'b0;
      nxt_ix  = 1'b0;
      if (in_round_en) begin
         case (cw_ps)
            PS_NARROW: begin nxt_sig = lane_sig[0]; nxt_cy = lane_cy[0]; nxt_ix = lane_ix[0]; end
            PS_MID:    begin nxt_sig = lane_sig[1]; nxt_cy = lane_cy[1]; nxt_ix = lane_ix[1]; end
            default:   begin nxt_sig = lane_sig[2]; nxt_cy = lane_cy[2]; nxt_ix = lane_ix[2]; end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_sig     <= '0;
         out_exp_inc <= 1'b0;
         out_inexact <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_sig     <= nxt_sig;
            out_exp_inc <= nxt_cy;
            out_inexact <= nxt_ix;
         end
      end
   end

   xpr_pe_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_i    (in_valid & nxt_ix),
      .masked_i  (cw_pe_masked),
      .status_o  (pe_status),
      .unmasked_o(out_pe_unmasked)
   );

   assert_one_stage_R11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_carry_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_exp_inc) |-> (out_sig == TOP_ONLY));
   assert_chop_no_grow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_round_en && cw_q[RC_LSB +: 2] == 2'b11)
         |=> (!out_exp_inc && out_sig <= $past(in_sig)));
   assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_round_en)
         |=> (out_sig == $past(in_sig) && !out_inexact && !out_exp_inc));
   assert_unmask_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_pe_unmasked |-> (out_valid && out_inexact));
   assert_status_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_inexact) |-> pe_status);

endmodule

// File: tb/sim_xpr_round_unit.sv
`timescale 1ns/1ps
module sim_xpr_round_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cw_we = 1'b0;
   logic [15:0] cw_wdata = '0;
   logic [15:0] cw_q;
   logic        in_valid = 1'b0;
   logic        in_round_en = 1'b0;
   logic        in_sign = 1'b0;
   logic [63:0] in_sig = '0;
   logic [2:0]  in_grs = '0;
   logic        out_valid;
   logic [63:0] out_sig;
   logic        out_exp_inc;
   logic        out_inexact;
   logic        out_pe_unmasked;
   logic        pe_status;

   always #2 clk = ~clk;

   xpr_round_unit u0 (
      .clk(clk), .rst_n(rst_n), .cw_we(cw_we), .cw_wdata(cw_wdata), .cw_q(cw_q),
      .in_valid(in_valid), .in_round_en(in_round_en), .in_sign(in_sign),
      .in_sig(in_sig), .in_grs(in_grs), .out_valid(out_valid), .out_sig(out_sig),
      .out_exp_inc(out_exp_inc), .out_inexact(out_inexact),
      .out_pe_unmasked(out_pe_unmasked), .pe_status(pe_status)
   );

   typedef struct {
      logic [63:0] sig;
      logic        xinc;
      logic        inex;
      logic        unm;
      string       tag;
   } exp_t;

   exp_t        q[$];
   int          n_chk = 0;
   int          n_bad = 0;
   logic [15:0] cw_m = 16'h037F;
   logic        st_m = 1'b0;
   logic        mon_on = 1'b0;
   logic        done = 1'b0;

   task automatic chk(input logic ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Reference built from the requirements: compare discarded part against one half ulp.
   function automatic exp_t model(logic [15:0] w, logic s, logic [63:0] m,
                                  logic [2:0] g, logic en, string tag);
      exp_t r;
      int p;
      int drop;
      logic [66:0] ext, disc, half;
      logic [63:0] trunc;
      logic [64:0] sum;
      logic up;
      r.tag = tag; r.sig = m; r.xinc = 1'b0; r.inex = 1'b0; r.unm = 1'b0;
      if (en) begin
         case (w[9:8])
            2'b00:   p = 24;
            2'b10:   p = 53;
            default: p = 64;
         endcase
         drop  = 64 - p;
         ext   = {m, g};
         disc  = ext & ((67'd1 << (drop + 3)) - 67'd1);
         half  = 67'd1 << (drop + 2);
         trunc = m & ~((64'd1 << drop) - 64'd1);
         case (w[11:10])
            2'b00:   up = (disc > half) || (disc == half && m[drop]);
            2'b01:   up = s && (disc != 0);
            2'b10:   up = !s && (disc != 0);
            default: up = 1'b0;
         endcase
         sum = {1'b0, trunc} + (65'd1 << drop);
         if (up && sum[64]) begin
            r.sig = 64'h8000_0000_0000_0000; r.xinc = 1'b1;
         end else if (up) r.sig = sum[63:0];
         else             r.sig = trunc;
         r.inex = (disc != 0);
         r.unm  = r.inex && !w[5];
      end
      return r;
   endfunction

   task automatic send(input string tag, input logic s, input logic [63:0] m,
                       input logic [2:0] g, input logic en);
      @(negedge clk);
      cw_we = 1'b0; in_valid = 1'b1; in_round_en = en; in_sign = s; in_sig = m; in_grs = g;
      q.push_back(model(cw_m, s, m, g, en, tag));
   endtask

   // Request and control-word write in the same cycle (R12).
   task automatic send_wr(input logic [15:0] w, input logic s, input logic [63:0] m,
                          input logic [2:0] g);
      @(negedge clk);
      cw_we = 1'b1; cw_wdata = w;
      in_valid = 1'b1; in_round_en = 1'b1; in_sign = s; in_sig = m; in_grs = g;
      q.push_back(model(cw_m, s, m, g, 1'b1, "R12"));
      cw_m = w;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cw_we = 1'b0; in_valid = 1'b0;
      end
   endtask

   task automatic wr(input logic [15:0] w);
      @(negedge clk);
      in_valid = 1'b0; cw_we = 1'b1; cw_wdata = w;
      cw_m = w;
      @(negedge clk);
      cw_we = 1'b0; in_valid = 1'b0;
      chk(cw_q == w, "R1", "control word readback", {48'd0, cw_q}, {48'd0, w});
   endtask

   // Monitor: pops one expected item per out_valid cycle.
   always @(negedge clk) begin
      if (mon_on) begin
         if (out_valid) begin
            if (q.size() == 0) begin
               chk(1'b0, "R11", "out_valid with nothing pending", 64'd1, 64'd0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(out_sig == e.sig, e.tag, "out_sig", out_sig, e.sig);
               chk(out_exp_inc == e.xinc, {e.tag, "/R6"}, "out_exp_inc",
                   {63'd0, out_exp_inc}, {63'd0, e.xinc});
               chk(out_inexact == e.inex, {e.tag, "/R7"}, "out_inexact",
                   {63'd0, out_inexact}, {63'd0, e.inex});
               chk(out_pe_unmasked == e.unm, {e.tag, "/R9"}, "out_pe_unmasked",
                   {63'd0, out_pe_unmasked}, {63'd0, e.unm});
               st_m = st_m | e.inex;
               chk(pe_status == st_m, {e.tag, "/R8"}, "pe_status",
                   {63'd0, pe_status}, {63'd0, st_m});
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      // R1 / R8 / R11: reset state
      chk(cw_q == 16'h037F, "R1", "reset control word", {48'd0, cw_q}, 64'h037F);
      chk(pe_status == 1'b0, "R8", "reset status", {63'd0, pe_status}, 64'd0);
      chk(out_valid == 1'b0, "R11", "reset out_valid", {63'd0, out_valid}, 64'd0);

      // R10: pass-through leaves status clear
      send("R10", 1'b1, 64'hDEAD_BEEF_1234_5679, 3'b111, 1'b0);
      send("R10", 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 3'b110, 1'b0);
      idle(2);
      chk(pe_status == 1'b0, "R10", "status after bypass", {63'd0, pe_status}, 64'd0);

      // R7: exact at 64 bits; R3: nearest-even at 64 bits (default word)
      send("R7", 1'b0, 64'h8000_0000_0000_0003, 3'b000, 1'b1);
      send("R3", 1'b0, 64'h8000_0000_0000_0000, 3'b100, 1'b1);
      send("R3", 1'b0, 64'h8000_0000_0000_0001, 3'b100, 1'b1);
      send("R3", 1'b1, 64'h8000_0000_0000_0004, 3'b101, 1'b1);
      send("R3", 1'b0, 64'h8000_0000_0000_0004, 3'b011, 1'b1);
      // R6: carry out at 64 bits
      send("R6", 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 3'b110, 1'b1);
      // R8: exact result afterwards leaves status set
      send("R8", 1'b0, 64'hC000_0000_0000_0000, 3'b000, 1'b1);
      idle(2);

      // R2/R5/R9: 24 bits, toward +inf, precision mask clear, a spare bit set
      wr(16'h181F);
      send("R5", 1'b0, 64'h8000_0100_0000_0000, 3'b001, 1'b1);
      send("R5", 1'b1, 64'h8000_0100_0000_0000, 3'b001, 1'b1);
      send("R2", 1'b0, 64'hABCD_EF00_0000_0000, 3'b000, 1'b1);
      idle(2);
      // R5: 53 bits, toward -inf
      wr(16'h063F);
      send("R5", 1'b1, 64'h8000_0000_0000_0401, 3'b000, 1'b1);
      send("R5", 1'b0, 64'h8000_0000_0000_0401, 3'b000, 1'b1);
      idle(2);
      // R4 + R2: chop with the unused precision code (behaves as 64 bits)
      wr(16'h0D3F);
      send("R4", 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 3'b111, 1'b1);
      send("R2", 1'b1, 64'h8000_0000_0000_0001, 3'b100, 1'b1);
      idle(2);
      // R6: carry at 24 bits with nearest-even
      wr(16'h003F);
      send("R6", 1'b0, 64'hFFFF_FF80_0000_0000, 3'b000, 1'b1);
      // R12: request uses the old word while a new one is written
      send_wr(16'h0C1F, 1'b0, 64'hFFFF_FF80_0000_0000, 3'b000);
      send("R12", 1'b0, 64'hFFFF_FF80_0000_0000, 3'b000, 1'b1);
      idle(2);

      // R11: back-to-back random traffic across all words
      for (int k = 0; k < 400; k++) begin
         if (k % 40 == 0) begin
            logic [15:0] w;
            w = 16'($urandom);
            idle(1);
            wr(w);
         end
         send("R11", 1'($urandom), {$urandom, $urandom}, 3'($urandom),
              ($urandom % 8) != 0);
      end
      idle(3);
      chk(q.size() == 0, "R11", "results outstanding", 64'(q.size()), 64'd0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule